// File: doc/BRIEF.md
# Parallel Flash Program and Erase Sequencer

This block is the host-side master for an asynchronous x16 parallel flash. A single request carries an operation (word program, sector erase, block erase or whole-array erase), a target word address and, for a program, the word to store. The sequencer turns the request into the unlock-and-command write cycles the flash expects. It drives chip enable, output enable and write enable itself. Every pulse width, setup and hold is counted in clock cycles, rounded up from nanosecond parameters and the clock period.

Once the last command write is issued, the block polls the flash. It repeatedly reads the target address and watches bit 6 of the returned word. That bit flips on every read while the flash is busy. The operation counts as finished only when two consecutive reads agree and two further reads agree with them as well. This rejects a reply that looks settled only because a poll landed on the completion instant. A watchdog bounds the polling phase. After reset the block refuses work until a power-up interval has elapsed.

The request port is a valid/ready sink. The requester holds `req_valid` and the request fields stable until a cycle in which `req_ready` is also high. `req_ready` is high only while the sequencer is idle, so it applies back-pressure for the whole operation. Completion is reported by a one-cycle `done` pulse, qualified by `err`.

Top module: `flash_pe_seq`

## Requirements
- R1: For the power-up interval (POWERUP_NS rounded up to whole clock cycles) after reset is released, `req_ready` is low and `fl_ce_n` stays high.
- R2: A request is taken in a cycle where `req_valid` and `req_ready` are both high. `req_ready` then stays low until the `done` pulse of that request.
- R3: Operation codes are 0 for word program, 1 for sector erase, 2 for block erase and 3 for whole-array erase. Command writes use word addresses 0x5555 and 0x2AAA with all higher address bits zero. A word program writes 0xAA@0x5555, 0x55@0x2AAA, 0xA0@0x5555, then the request data at the request address. An erase writes 0xAA@0x5555, 0x55@0x2AAA, 0x80@0x5555, 0xAA@0x5555, 0x55@0x2AAA, and then one final write. For a sector erase that write is 0x30 at the request address. For a block erase it is 0x50 at the request address. For a whole-array erase it is 0x10 at 0x5555.
- R4: Each write holds `fl_we_n` low for at least ceil(max(40, 30, 30) ns / period) cycles. Address and write data stay stable for as long as `fl_we_n` is low.
- R5: Between two writes, `fl_we_n` stays high for at least ceil(max(30, 10) ns / period) cycles. `fl_oe_n` and `fl_we_n` are never low together.
- R6: Status reads address the request address with `fl_ce_n` and `fl_oe_n` low and `fl_we_n` high. The data bus is released (`fl_dq_oe` low) during these reads.
- R7: Completion is declared on the read that makes bit 6 equal across two consecutive reads followed by two more equal reads. `done` is then pulsed with `err` low, and no further read is issued.
- R8: If either of the two confirming reads differs, the equal pair is discarded and polling continues. The differing read becomes the new reference.
- R9: If completion has not been declared within TIMEOUT_NS (in cycles) of the start of polling, the sequencer pulses `done` with `err` high after the read in progress.
- R10: `done` is high for exactly one cycle per request. `err` is never high without `done`.
- R11: After a request that ended with `err`, the next request is accepted and carried out normally.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Sequencer idle and able to take a request |
| req_op | input | 2 | Operation code (see R3) |
| req_addr | input | AW | Target word address |
| req_data | input | DW | Word to program |
| done | output | 1 | One-cycle completion pulse |
| err | output | 1 | Watchdog expiry, valid with `done` |
| fl_addr | output | AW | Flash address |
| fl_dq_out | output | DW | Flash write data |
| fl_dq_oe | output | 1 | Drive enable for `fl_dq_out` |
| fl_dq_in | input | DW | Flash read data |
| fl_ce_n | output | 1 | Flash chip enable, active low |
| fl_oe_n | output | 1 | Flash output enable, active low |
| fl_we_n | output | 1 | Flash write enable, active low |

## Verification
The sequencer is driven with all four operation codes against a bench flash model. The model answers bit 6 by toggling for a chosen number of reads and then holding steady. The exact number of reads tells whether the double confirmation is applied, because a single confirming read would stop earlier.

Two patterns insert a read that repeats its predecessor while the flash is still busy. One of them places this repeat right at completion. The first must not end early; the second must end exactly four reads after the stored reference. A flash that never settles separates the watchdog path from normal completion. A zero-busy reply shows the shortest possible poll.

// File: rtl/fseq_pkg.sv
package fseq_pkg;

  typedef enum logic [1:0] {
    OP_WORD   = 2'd0,
    OP_SECTOR = 2'd1,
    OP_BLOCK  = 2'd2,
    OP_CHIP   = 2'd3
  } fseq_op_e;

  typedef enum logic [2:0] {
    BP_IDLE, BP_WLO, BP_WHI, BP_RLO, BP_RHI
  } phy_st_e;

  typedef enum logic [2:0] {
    ST_PWR, ST_IDLE, ST_WISS, ST_WWAIT, ST_RISS, ST_RWAIT
  } seq_st_e;

  localparam logic [14:0] UNLOCK_A = 15'h5555;
  localparam logic [14:0] UNLOCK_B = 15'h2AAA;

  localparam logic [7:0] CD_KEY_A  = 8'hAA;
  localparam logic [7:0] CD_KEY_B  = 8'h55;
  localparam logic [7:0] CD_WORD   = 8'hA0;
  localparam logic [7:0] CD_ERASE  = 8'h80;
  localparam logic [7:0] CD_SECTOR = 8'h30;
  localparam logic [7:0] CD_BLOCK  = 8'h50;
  localparam logic [7:0] CD_CHIP   = 8'h10;

  // nanoseconds to clock cycles, rounded up, never below one
  function automatic int ns2cyc(input int ns, input int per);
    int r;
    r = (ns + per - 1) / per;
    return (r < 1) ? 1 : r;
  endfunction

endpackage

// File: rtl/fseq_cmd_rom.sv
module fseq_cmd_rom
  import fseq_pkg::*;
#(
  parameter int AW = 21,
  parameter int DW = 16
) (
  input  fseq_op_e        op,
  input  logic [2:0]      idx,
  input  logic [AW-1:0]   tgt_addr,
  input  logic [DW-1:0]   tgt_data,
  output logic [AW-1:0]   cmd_addr,
  output logic [DW-1:0]   cmd_data,
  output logic            cmd_last
);

  localparam logic [AW-1:0] KA = AW'(UNLOCK_A);
  localparam logic [AW-1:0] KB = AW'(UNLOCK_B);

  always_comb begin
    cmd_addr = KA;
    cmd_data = DW'(CD_KEY_A);
    case (idx)
      3'd0: begin cmd_addr = KA; cmd_data = DW'(CD_KEY_A); end
      3'd1: begin cmd_addr = KB; cmd_data = DW'(CD_KEY_B); end
      3'd2: begin
        cmd_addr = KA;
        cmd_data = (op == OP_WORD) ? DW'(CD_WORD) : DW'(CD_ERASE);
      end
      3'd3: begin
        if (op == OP_WORD) begin
          cmd_addr = tgt_addr;
          cmd_data = tgt_data;
        end else begin
          cmd_addr = KA;
          cmd_data = DW'(CD_KEY_A);
        end
      end
      3'd4: begin cmd_addr = KB; cmd_data = DW'(CD_KEY_B); end
      default: begin
        case (op)
          OP_SECTOR: begin cmd_addr = tgt_addr; cmd_data = DW'(CD_SECTOR); end
          OP_BLOCK:  begin cmd_addr = tgt_addr; cmd_data = DW'(CD_BLOCK); end
          default:   begin cmd_addr = KA;       cmd_data = DW'(CD_CHIP); end
        endcase
      end
    endcase
    cmd_last = (op == OP_WORD) ? (idx == 3'd3) : (idx == 3'd5);
  end

endmodule

// File: rtl/fseq_bus_phy.sv
module fseq_bus_phy
  import fseq_pkg::*;
#(
  parameter int AW        = 21,
  parameter int DW        = 16,
  parameter int WLOW_CYC  = 5,
  parameter int WHIGH_CYC = 4,
  parameter int RACC_CYC  = 9,
  parameter int RREC_CYC  = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic          rd,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] wdata,
  output logic          cyc_done,
  output logic [DW-1:0] rdata,
  output logic [AW-1:0] fl_addr,
  output logic [DW-1:0] fl_dq_out,
  output logic          fl_dq_oe,
  input  logic [DW-1:0] fl_dq_in,
  output logic          fl_ce_n,
  output logic          fl_oe_n,
  output logic          fl_we_n
);

  localparam int M1 = (WLOW_CYC > WHIGH_CYC) ? WLOW_CYC : WHIGH_CYC;
  localparam int M2 = (RACC_CYC > RREC_CYC) ? RACC_CYC : RREC_CYC;
  localparam int MX = (M1 > M2) ? M1 : M2;
  localparam int CW = $clog2(MX + 1);

  phy_st_e       st;
  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st        <= BP_IDLE;
      cnt       <= '0;
      cyc_done  <= 1'b0;
      rdata     <= '0;
      fl_addr   <= '0;
      fl_dq_out <= '0;
      fl_dq_oe  <= 1'b0;
      fl_ce_n   <= 1'b1;
      fl_oe_n   <= 1'b1;
      fl_we_n   <= 1'b1;
    end else begin
      cyc_done <= 1'b0;
      case (st)
        BP_IDLE: if (start) begin
          fl_addr <= addr;
          fl_ce_n <= 1'b0;
          cnt     <= '0;
          if (rd) begin
            fl_oe_n  <= 1'b0;
            fl_dq_oe <= 1'b0;
            st       <= BP_RLO;
          end else begin
            fl_dq_out <= wdata;
            fl_dq_oe  <= 1'b1;
            fl_we_n   <= 1'b0;
            st        <= BP_WLO;
          end
        end
        BP_WLO: begin
          if (cnt == CW'(WLOW_CYC - 1)) begin
            fl_we_n <= 1'b1;
            cnt     <= '0;
            st      <= BP_WHI;
          end else cnt <= cnt + 1'b1;
        end
        BP_WHI: begin
          if (cnt == CW'(WHIGH_CYC - 1)) begin
            fl_ce_n  <= 1'b1;
            fl_dq_oe <= 1'b0;
            cyc_done <= 1'b1;
            st       <= BP_IDLE;
          end else cnt <= cnt + 1'b1;
        end
        BP_RLO: begin
          if (cnt == CW'(RACC_CYC - 1)) begin
            rdata   <= fl_dq_in;
            fl_oe_n <= 1'b1;
            fl_ce_n <= 1'b1;
            cnt     <= '0;
            st      <= BP_RHI;
          end else cnt <= cnt + 1'b1;
        end
        BP_RHI: begin
          if (cnt == CW'(RREC_CYC - 1)) begin
            cyc_done <= 1'b1;
            st       <= BP_IDLE;
          end else cnt <= cnt + 1'b1;
        end
        default: st <= BP_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/fseq_toggle_chk.sv
module fseq_toggle_chk #(
  parameter int CONFIRM_READS = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clear,
  input  logic smp_valid,
  input  logic smp_bit,
  output logic finished
);

  localparam int KW = $clog2(CONFIRM_READS + 1);

  logic          have_ref;
  logic          ref_bit;
  logic [KW-1:0] agree;
  logic          match;

  assign match    = have_ref && (smp_bit == ref_bit);
  assign finished = smp_valid && match && (agree == KW'(CONFIRM_READS));

  always_ff @(posedge clk) begin
    if (!rst_n || clear) begin
      have_ref <= 1'b0;
      ref_bit  <= 1'b0;
      agree    <= '0;
    end else if (smp_valid) begin
      have_ref <= 1'b1;
      ref_bit  <= smp_bit;
      if (!match) agree <= '0;
      else if (agree != KW'(CONFIRM_READS)) agree <= agree + 1'b1;
    end
  end

endmodule

// File: rtl/flash_pe_seq.sv
module flash_pe_seq
  import fseq_pkg::*;
#(
  parameter int AW            = 21,
  parameter int DW            = 16,
  parameter int CLK_PERIOD_NS = 8,
  parameter int T_WP_NS       = 40,
  parameter int T_WPH_NS      = 30,
  parameter int T_AH_NS       = 30,
  parameter int T_DS_NS       = 30,
  parameter int T_OEH_NS      = 10,
  parameter int T_ACC_NS      = 70,
  parameter int T_RREC_NS     = 30,
  parameter int POWERUP_NS    = 100000,
  parameter int TIMEOUT_NS    = 100000000,
  parameter int STAT_BIT      = 6,
  parameter int CONFIRM_READS = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_valid,
  output logic          req_ready,
  input  logic [1:0]    req_op,
  input  logic [AW-1:0] req_addr,
  input  logic [DW-1:0] req_data,
  output logic          done,
  output logic          err,
  output logic [AW-1:0] fl_addr,
  output logic [DW-1:0] fl_dq_out,
  output logic          fl_dq_oe,
  input  logic [DW-1:0] fl_dq_in,
  output logic          fl_ce_n,
  output logic          fl_oe_n,
  output logic          fl_we_n
);

  localparam int WL_NS     = (T_WP_NS > T_AH_NS) ? ((T_WP_NS > T_DS_NS) ? T_WP_NS : T_DS_NS)
                                                 : ((T_AH_NS > T_DS_NS) ? T_AH_NS : T_DS_NS);
  localparam int WLOW_CYC  = ns2cyc(WL_NS, CLK_PERIOD_NS);
  localparam int WHIGH_CYC = ns2cyc((T_WPH_NS > T_OEH_NS) ? T_WPH_NS : T_OEH_NS, CLK_PERIOD_NS);
  localparam int RACC_CYC  = ns2cyc(T_ACC_NS, CLK_PERIOD_NS);
  localparam int RREC_CYC  = ns2cyc(T_RREC_NS, CLK_PERIOD_NS);
  localparam int PWR_CYC   = ns2cyc(POWERUP_NS, CLK_PERIOD_NS);
  localparam int TMO_CYC   = ns2cyc(TIMEOUT_NS, CLK_PERIOD_NS);
  localparam int PW        = $clog2(PWR_CYC + 1);
  localparam int TW        = $clog2(TMO_CYC + 1);

  seq_st_e       st;
  fseq_op_e      op_q;
  logic [AW-1:0] addr_q;
  logic [DW-1:0] data_q;
  logic [2:0]    idx_q;
  logic [PW-1:0] pwr_cnt;
  logic [TW-1:0] wd_cnt;
  logic          wd_exp;
  logic          done_q, err_q;

  logic [AW-1:0] rom_addr;
  logic [DW-1:0] rom_data;
  logic          rom_last;
  logic          phy_start, phy_rd, phy_done;
  logic [AW-1:0] phy_addr;
  logic [DW-1:0] phy_rdata;
  logic          det_clear, det_smp, det_fin;
  logic          unused_rd;

  fseq_cmd_rom #(.AW(AW), .DW(DW)) u_rom (
    .op(op_q), .idx(idx_q), .tgt_addr(addr_q), .tgt_data(data_q),
    .cmd_addr(rom_addr), .cmd_data(rom_data), .cmd_last(rom_last)
  );

  assign phy_start = (st == ST_WISS) || (st == ST_RISS);
  assign phy_rd    = (st == ST_RISS);
  assign phy_addr  = phy_rd ? addr_q : rom_addr;

  fseq_bus_phy #(
    .AW(AW), .DW(DW), .WLOW_CYC(WLOW_CYC), .WHIGH_CYC(WHIGH_CYC),
    .RACC_CYC(RACC_CYC), .RREC_CYC(RREC_CYC)
  ) u_phy (
    .clk(clk), .rst_n(rst_n), .start(phy_start), .rd(phy_rd),
    .addr(phy_addr), .wdata(rom_data), .cyc_done(phy_done), .rdata(phy_rdata),
    .fl_addr(fl_addr), .fl_dq_out(fl_dq_out), .fl_dq_oe(fl_dq_oe),
    .fl_dq_in(fl_dq_in), .fl_ce_n(fl_ce_n), .fl_oe_n(fl_oe_n), .fl_we_n(fl_we_n)
  );

  assign det_clear = (st == ST_WWAIT) && phy_done && rom_last;
  assign det_smp   = (st == ST_RWAIT) && phy_done;
  assign unused_rd = ^phy_rdata;

  fseq_toggle_chk #(.CONFIRM_READS(CONFIRM_READS)) u_det (
    .clk(clk), .rst_n(rst_n), .clear(det_clear), .smp_valid(det_smp),
    .smp_bit(phy_rdata[STAT_BIT]), .finished(det_fin)
  );

  assign wd_exp    = (wd_cnt == TW'(TMO_CYC));
  assign req_ready = (st == ST_IDLE);
  assign done      = done_q;
  assign err       = err_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st      <= ST_PWR;
      op_q    <= OP_WORD;
      addr_q  <= '0;
      data_q  <= '0;
      idx_q   <= '0;
      pwr_cnt <= '0;
      wd_cnt  <= '0;
      done_q  <= 1'b0;
      err_q   <= 1'b0;
    end else begin
      done_q <= 1'b0;
      err_q  <= 1'b0;
      if (((st == ST_RISS) || (st == ST_RWAIT)) && !wd_exp) wd_cnt <= wd_cnt + 1'b1;
      case (st)
        ST_PWR: begin
          if (pwr_cnt == PW'(PWR_CYC - 1)) st <= ST_IDLE;
          else pwr_cnt <= pwr_cnt + 1'b1;
        end
        ST_IDLE: if (req_valid) begin
          op_q   <= fseq_op_e'(req_op);
          addr_q <= req_addr;
          data_q <= req_data;
          idx_q  <= '0;
          st     <= ST_WISS;
        end
        ST_WISS: st <= ST_WWAIT;
        ST_WWAIT: if (phy_done) begin
          if (rom_last) begin
            wd_cnt <= '0;
            st     <= ST_RISS;
          end else begin
            idx_q <= idx_q + 1'b1;
            st    <= ST_WISS;
          end
        end
        ST_RISS: st <= ST_RWAIT;
        ST_RWAIT: if (phy_done) begin
          if (det_fin) begin
            done_q <= 1'b1;
            st     <= ST_IDLE;
          end else if (wd_exp) begin
            done_q <= 1'b1;
            err_q  <= 1'b1;
            st     <= ST_IDLE;
          end else st <= ST_RISS;
        end
        default: st <= ST_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/fseq_chk.sv
module fseq_chk #(
  parameter int AW       = 21,
  parameter int DW       = 16,
  parameter int WLOW_CYC = 5,
  parameter int PWR_CYC  = 100
) (
  input logic          clk,
  input logic          rst_n,
  input logic          req_valid,
  input logic          req_ready,
  input logic          done,
  input logic          err,
  input logic [AW-1:0] fl_addr,
  input logic [DW-1:0] fl_dq_out,
  input logic          fl_dq_oe,
  input logic          fl_ce_n,
  input logic          fl_oe_n,
  input logic          fl_we_n
);

  localparam int PW = $clog2(PWR_CYC + 1);
  localparam int LW = $clog2(WLOW_CYC + 2);

  logic [PW-1:0] since_rst;
  logic [LW-1:0] low_run;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      since_rst <= '0;
      low_run   <= '0;
    end else begin
      if (since_rst != PW'(PWR_CYC)) since_rst <= since_rst + 1'b1;
      if (fl_we_n) low_run <= '0;
      else if (low_run != LW'(WLOW_CYC + 1)) low_run <= low_run + 1'b1;
    end
  end

  a_r1_pwr_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (since_rst < PW'(PWR_CYC)) |-> (fl_ce_n && !req_ready));

  a_r2_busy_after_accept: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> !req_ready);

  a_r4_we_width: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(fl_we_n) |-> (low_run >= LW'(WLOW_CYC)));

  a_r4_write_stable: assert property (@(posedge clk) disable iff (!rst_n)
    (!fl_we_n && $past(!fl_we_n)) |-> ($stable(fl_addr) && $stable(fl_dq_out)));

  a_r5_oe_we_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    !(!fl_we_n && !fl_oe_n));

  a_r6_read_released: assert property (@(posedge clk) disable iff (!rst_n)
    !fl_oe_n |-> (!fl_dq_oe && !fl_ce_n && fl_we_n));

  a_r10_done_single: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  a_r10_err_with_done: assert property (@(posedge clk) disable iff (!rst_n)
    err |-> done);

endmodule

bind flash_pe_seq fseq_chk #(
  .AW(AW), .DW(DW), .WLOW_CYC(WLOW_CYC), .PWR_CYC(PWR_CYC)
) u_chk (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
  .done(done), .err(err), .fl_addr(fl_addr), .fl_dq_out(fl_dq_out),
  .fl_dq_oe(fl_dq_oe), .fl_ce_n(fl_ce_n), .fl_oe_n(fl_oe_n), .fl_we_n(fl_we_n)
);

// File: tb/sim_flash_pe_seq.sv
module sim_flash_pe_seq;

  localparam int PER    = 8;
  localparam int PWR_NS = 4000;
  localparam int TMO_NS = 40000;
  localparam int PWR_C  = PWR_NS / PER;
  localparam int WL_MIN = 5;
  localparam int WH_MIN = 4;

  typedef struct packed {
    logic [1:0]  op;
    logic [20:0] addr;
    logic [15:0] data;
    logic [15:0] busy;
    logic [15:0] glitch;
    logic [15:0] reads;
  } vec_t;

  localparam vec_t VEC [5] = '{
    '{2'd0, 21'h12345, 16'hBEEF, 16'd4, 16'd0, 16'd7},
    '{2'd1, 21'h1F800, 16'h0000, 16'd5, 16'd0, 16'd9},
    '{2'd2, 21'h18000, 16'h0000, 16'd6, 16'd3, 16'd9},
    '{2'd3, 21'h00000, 16'h0000, 16'd3, 16'd2, 16'd5},
    '{2'd0, 21'h1FFFF, 16'h0001, 16'd0, 16'd0, 16'd4}
  };

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [1:0]  req_op = '0;
  logic [20:0] req_addr = '0;
  logic [15:0] req_data = '0;
  logic        done, err;
  logic [20:0] fl_addr;
  logic [15:0] fl_dq_out;
  logic        fl_dq_oe;
  logic [15:0] fl_dq_in;
  logic        fl_ce_n, fl_oe_n, fl_we_n;

  always #4 clk = ~clk;

  flash_pe_seq #(
    .CLK_PERIOD_NS(PER), .POWERUP_NS(PWR_NS), .TIMEOUT_NS(TMO_NS)
  ) u0 (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_op(req_op), .req_addr(req_addr), .req_data(req_data),
    .done(done), .err(err), .fl_addr(fl_addr), .fl_dq_out(fl_dq_out),
    .fl_dq_oe(fl_dq_oe), .fl_dq_in(fl_dq_in), .fl_ce_n(fl_ce_n),
    .fl_oe_n(fl_oe_n), .fl_we_n(fl_we_n)
  );

  // flash model
  int          busy_n = 0;
  int          glitch_at = 0;
  int          rd_cnt = 0;
  int          wr_n = 0;
  logic [20:0] wr_a [8];
  logic [15:0] wr_d [8];

  function automatic logic stat_bit(input int i);
    if (i < busy_n) begin
      if (glitch_at != 0 && i == glitch_at) return 1'((i - 1) & 1);
      return 1'(i & 1);
    end
    return 1'b1;
  endfunction

  assign fl_dq_in = 16'hFFBF | (16'(stat_bit(rd_cnt)) << 6);

  always @(posedge fl_oe_n) rd_cnt = rd_cnt + 1;
  always @(posedge fl_we_n) begin
    if (!fl_ce_n && fl_dq_oe && wr_n < 8) begin
      wr_a[wr_n] = fl_addr;
      wr_d[wr_n] = fl_dq_out;
      wr_n = wr_n + 1;
    end
  end

  // bus monitor
  int          wl_run = 0, wh_run = 0, min_wl = 1000, min_wh = 1000, bad_rd = 0;
  logic [20:0] cur_addr = '0;
  always @(negedge clk) begin
    if (!fl_we_n) begin
      if (wh_run > 0 && wr_n > 0 && wh_run < min_wh) min_wh = wh_run;
      wh_run = 0;
      wl_run = wl_run + 1;
    end else begin
      if (wl_run > 0 && wl_run < min_wl) min_wl = wl_run;
      wl_run = 0;
      wh_run = wh_run + 1;
    end
    if (!fl_oe_n && (fl_dq_oe || !fl_we_n || fl_ce_n || fl_addr != cur_addr)) bad_rd = bad_rd + 1;
  end

  int nchk = 0, nerr = 0, cyc = 0;
  bit fin = 1'b0;

  task automatic chk(input bit ok, input string rq, input string what,
                     input longint act, input longint exp);
    nchk = nchk + 1;
    if (!ok) begin
      nerr = nerr + 1;
      $display("FAIL %s %s: actual=%0h expected=%0h", rq, what, act, exp);
    end
  endtask

  function automatic void exp_wr(input logic [1:0] op, input int k,
                                 input logic [20:0] a, input logic [15:0] d,
                                 output logic [20:0] ea, output logic [15:0] ed);
    logic [20:0] k1, k2;
    k1 = 21'h05555;
    k2 = 21'h02AAA;
    ea = k1; ed = 16'h00AA;
    case (k)
      1: begin ea = k2; ed = 16'h0055; end
      2: ed = (op == 2'd0) ? 16'h00A0 : 16'h0080;
      3: if (op == 2'd0) begin ea = a; ed = d; end
      4: begin ea = k2; ed = 16'h0055; end
      5: case (op)
           2'd1: begin ea = a; ed = 16'h0030; end
           2'd2: begin ea = a; ed = 16'h0050; end
           default: begin ea = k1; ed = 16'h0010; end
         endcase
      default: ;
    endcase
  endfunction

  task automatic run_op(input logic [1:0] op, input logic [20:0] a, input logic [15:0] d,
                        input int b, input int g, input int exp_reads, input bit exp_err);
    int w;
    logic [20:0] ea;
    logic [15:0] ed;
    busy_n = b; glitch_at = g; rd_cnt = 0; wr_n = 0;
    min_wl = 1000; min_wh = 1000; bad_rd = 0; cur_addr = a;
    w = 0;
    while (!req_ready && w < 1000) begin @(negedge clk); w++; end
    req_op = op; req_addr = a; req_data = d; req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    chk(!req_ready, "R2", "ready after accept", req_ready, 0);
    w = 0;
    while (!done && w < 20000) begin
      @(negedge clk);
      w++;
      if (w == 20 && req_ready) chk(0, "R2", "ready mid operation", 1, 0);
    end
    chk(done, "R10", "done seen", done, 1);
    if (exp_err) chk(err == 1'b1, "R9", "err on timeout", err, 1);
    else chk(err == 1'b0, "R7", "err on completion", err, 0);
    chk(wr_n == ((op == 2'd0) ? 4 : 6), "R3", "write count", wr_n, (op == 2'd0) ? 4 : 6);
    for (int k = 0; k < wr_n && k < 6; k++) begin
      exp_wr(op, k, a, d, ea, ed);
      chk(wr_a[k] == ea, "R3", "write address", wr_a[k], ea);
      chk(wr_d[k] == ed, "R3", "write data", wr_d[k], ed);
    end
    if (!exp_err) chk(rd_cnt == exp_reads, (g != 0) ? "R8" : "R7", "status reads", rd_cnt, exp_reads);
    chk(min_wl >= WL_MIN, "R4", "we low width", min_wl, WL_MIN);
    chk(min_wh >= WH_MIN, "R5", "we high gap", min_wh, WH_MIN);
    chk(bad_rd == 0, "R6", "read bus state", bad_rd, 0);
    @(negedge clk);
    chk(!done && !err, "R10", "done pulse width", done, 0);
  endtask

  initial begin
    forever begin
      @(negedge clk);
      cyc++;
      if (cyc > 150000 && !fin) begin
        nerr++; nchk++;
        $display("FAIL watchdog: actual=%0d expected=%0d", cyc, 150000);
        $display("Result: errors=%0d of %0d checks", nerr, nchk);
        $finish;
      end
    end
  end

  initial begin
    int w;
    repeat (3) @(negedge clk);
    chk(!req_ready && fl_ce_n && fl_we_n && fl_oe_n, "R1", "reset state", req_ready, 0);
    chk(!done && !err, "R10", "reset outputs", done, 0);
    rst_n = 1'b1;
    w = 0;
    while (!req_ready && w < PWR_C + 50) begin
      @(negedge clk);
      w++;
      if (w == PWR_C - 20) chk(fl_ce_n && !req_ready, "R1", "quiet during power-up", req_ready, 0);
    end
    chk(w >= PWR_C - 1 && w <= PWR_C + 2, "R1", "power-up length", w, PWR_C);

    // vector table: main function across op codes and status patterns (R3, R7, R8)
    for (int i = 0; i < 5; i++)
      run_op(VEC[i].op, VEC[i].addr, VEC[i].data, int'(VEC[i].busy),
             int'(VEC[i].glitch), int'(VEC[i].reads), 1'b0);

    // R9: status never settles
    run_op(2'd1, 21'h0A800, 16'h0000, 1000000, 0, 0, 1'b1);
    // R11: normal request after an error
    run_op(2'd0, 21'h00042, 16'h5A5A, 2, 0, 5, 1'b0);

    fin = 1'b1;
    $display("Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end

endmodule